// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox

This block lets an 8-bit host processor and a 16-bit coprocessor pass single bytes to each other. Both sides share one data byte. The host reaches the mailbox through two adjacent I/O ports. One is the data port. The other returns status when the host reads it and takes a control byte when the host writes it. The coprocessor side has a data path, a write strobe for each of two active-low handshake lines, and an interrupt-enable register. The block also produces an interrupt request toward the coprocessor.

The host's own data accesses set its two ready flags. A host data write sets the transmit-ready flag and a host data read sets the receive-ready flag. The coprocessor's matching accesses clear them, so the host can poll the status port to learn whether the other side has taken or refilled the byte. Each host data access also pulls one handshake line low. The coprocessor sets each line high or low again by writing to specific handshake offsets. Bit 0 of the host control write holds the coprocessor in reset.

Only the low byte of the host I/O address enters the block, so the ports appear at every value of the upper address byte. Whenever the host and the coprocessor update the same register or flag in one clock, the coprocessor wins.

Top module: `cpu_mailbox`

## Requirements
- R1: After a synchronous reset, the data byte, both ready flags and the interrupt-enable register are 0, both handshake lines (`ack_n`, `stb_n`) are high, `cop_irq` is low and `cop_rst` is 1.
- R2: `c_rdata` always shows the shared data byte. The byte is replaced on the cycle after a host data-port write or a coprocessor data write. If both write in the same cycle, the coprocessor's byte is kept.
- R3: A host write to the data port (`h_port` = 0xB9) sets the transmit-ready flag and drives `stb_n` low on the next cycle.
- R4: A host read of the data port returns the data byte in the same cycle, then sets the receive-ready flag and drives `ack_n` low on the next cycle.
- R5: A coprocessor data write clears the receive-ready flag, and a coprocessor data read clears the transmit-ready flag. In both cases the coprocessor wins over a host access in the same cycle.
- R6: A host read of the status port (`h_port` = 0xB8) returns bits 7..4 as 1, bits 3..2 as 0, bit 1 as the transmit-ready flag and bit 0 as the receive-ready flag.
- R7: A host write to the status/control port sets `cop_rst` to bit 0 of the written byte. `cop_rst` keeps that value until the next such write.
- R8: A coprocessor handshake write to offset 0 or 1 drives `ack_n` low or high. Offset 4 or 5 drives `stb_n` low or high. Offsets 2, 3, 6 and 7 change nothing. A handshake write beats a host access that pulls the same line low in the same cycle.
- R9: A coprocessor interrupt-enable write stores all 6 bits, and `ien_q` shows them. `cop_irq` is high exactly when enable bit 0 is 1 and `irq_src_n` is low. `cop_vec` always reads 0x03.
- R10: Host accesses at any port value other than 0xB8 and 0xB9 change no state, and a host read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_port | input | 8 | Low byte of the host I/O address |
| h_wr | input | 1 | Host I/O write strobe |
| h_rd | input | 1 | Host I/O read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational) |
| c_data_wr | input | 1 | Coprocessor writes the data byte |
| c_data_rd | input | 1 | Coprocessor reads the data byte |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Shared data byte |
| c_hs_wr | input | 1 | Coprocessor handshake-control write |
| c_hs_off | input | 3 | Handshake-control offset |
| c_ien_wr | input | 1 | Coprocessor interrupt-enable write |
| c_ien_wdata | input | 6 | Interrupt-enable write data |
| irq_src_n | input | 1 | Active-low interrupt line from the parallel interface |
| ack_n | output | 1 | Input-acknowledge handshake line, active low |
| stb_n | output | 1 | Output-strobe handshake line, active low |
| ien_q | output | 6 | Interrupt-enable register contents |
| cop_irq | output | 1 | Interrupt request to the coprocessor |
| cop_vec | output | 8 | Interrupt vector for `cop_irq` |
| cop_rst | output | 1 | Coprocessor reset, active high |

## Verification
A wrong ready flag shows up in the very next status read, one cycle after the access that caused it. A deadlocked handshake would only surface later, so the bench reads status after every transfer step. A corrupted data byte shows on `c_rdata` at the next clock edge, and in the host's data read the same cycle. Handshake lines, the reset output and the enable register are compared every cycle, so a wrong priority between simultaneous host and coprocessor accesses is caught one cycle after the collision.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W   = 8;
    localparam int HS_LINES = 2;
    localparam int HS_ACK   = 0;
    localparam int HS_STB   = 1;
    localparam int IEN_MBX  = 0;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic ctrl_wr;
        logic stat_rd;
    } host_req_t;

    typedef struct packed {
        logic tx;
        logic rx;
    } ready_t;

    // handshake line n is pulled low at offset 4n and released at 4n+1
    function automatic int hs_lo_off(input int line);
        return line * 4;
    endfunction

    function automatic int hs_hi_off(input int line);
        return line * 4 + 1;
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input ready_t f);
        return {4'hF, 2'b00, f.tx, f.rx};
    endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
#(
    parameter int DEC_W = 8,
    parameter int BASE  = 'hB8
) (
    input  logic [DEC_W-1:0] h_port,
    input  logic             h_wr,
    input  logic             h_rd,
    output host_req_t        req
);
    localparam logic [DEC_W-1:0] CTRL_A = DEC_W'(BASE);
    localparam logic [DEC_W-1:0] DATA_A = DEC_W'(BASE + 1);

    logic hit_data;
    logic hit_ctrl;

    assign hit_data = (h_port == DATA_A);
    assign hit_ctrl = (h_port == CTRL_A);

    always_comb begin
        req.data_wr = h_wr && hit_data;
        req.data_rd = h_rd && hit_data;
        req.ctrl_wr = h_wr && hit_ctrl;
        req.stat_rd = h_rd && hit_ctrl;
    end
endmodule

// File: rtl/mbx_link.sv
module mbx_link
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_ev,
    input  logic              host_rd_ev,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              c_data_wr,
    input  logic              c_data_rd,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] data_q,
    output ready_t            rdy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (c_data_wr) begin
            data_q <= c_wdata;
        end else if (host_wr_ev) begin
            data_q <= h_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= '0;
        end else begin
            if (c_data_wr) begin
                rdy_q.rx <= 1'b0;
            end else if (host_rd_ev) begin
                rdy_q.rx <= 1'b1;
            end
            if (c_data_rd) begin
                rdy_q.tx <= 1'b0;
            end else if (host_wr_ev) begin
                rdy_q.tx <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbx_hs_line.sv
module mbx_hs_line #(
    parameter int OFF_W  = 3,
    parameter int LO_OFF = 0,
    parameter int HI_OFF = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_pull,
    input  logic             cop_wr,
    input  logic [OFF_W-1:0] cop_off,
    output logic             line_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
        end else if (cop_wr && cop_off == OFF_W'(HI_OFF)) begin
            line_q <= 1'b1;
        end else if (cop_wr && cop_off == OFF_W'(LO_OFF)) begin
            line_q <= 1'b0;
        end else if (host_pull) begin
            line_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_irq_gate.sv
module mbx_irq_gate
    import mbx_pkg::*;
#(
    parameter int IEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_wdata,
    input  logic             src_n,
    output logic [IEN_W-1:0] ien_q,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (ien_wr) begin
            ien_q <= ien_wdata;
        end
    end

    assign irq = ien_q[IEN_MBX] & ~src_n;
endmodule

// File: rtl/cpu_mailbox.sv
module cpu_mailbox
    import mbx_pkg::*;
#(
    parameter int DEC_W    = 8,
    parameter int BASE     = 'hB8,
    parameter int HS_OFF_W = 3,
    parameter int IEN_W    = 6,
    parameter int IRQ_VEC  = 'h03
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DEC_W-1:0]    h_port,
    input  logic                h_wr,
    input  logic                h_rd,
    input  logic [DATA_W-1:0]   h_wdata,
    output logic [DATA_W-1:0]   h_rdata,
    input  logic                c_data_wr,
    input  logic                c_data_rd,
    input  logic [DATA_W-1:0]   c_wdata,
    output logic [DATA_W-1:0]   c_rdata,
    input  logic                c_hs_wr,
    input  logic [HS_OFF_W-1:0] c_hs_off,
    input  logic                c_ien_wr,
    input  logic [IEN_W-1:0]    c_ien_wdata,
    input  logic                irq_src_n,
    output logic                ack_n,
    output logic                stb_n,
    output logic [IEN_W-1:0]    ien_q,
    output logic                cop_irq,
    output logic [DATA_W-1:0]   cop_vec,
    output logic                cop_rst
);
    host_req_t             req;
    ready_t                rdy;
    logic                  rx_flag;
    logic                  tx_flag;
    logic [DATA_W-1:0]     data_q;
    logic [HS_LINES-1:0]   pull;
    logic [HS_LINES-1:0]   line_q;

    mbx_host_decode #(.DEC_W(DEC_W), .BASE(BASE)) u_dec (
        .h_port (h_port),
        .h_wr   (h_wr),
        .h_rd   (h_rd),
        .req    (req)
    );

    mbx_link u_link (
        .clk        (clk),
        .rst        (rst),
        .host_wr_ev (req.data_wr),
        .host_rd_ev (req.data_rd),
        .h_wdata    (h_wdata),
        .c_data_wr  (c_data_wr),
        .c_data_rd  (c_data_rd),
        .c_wdata    (c_wdata),
        .data_q     (data_q),
        .rdy_q      (rdy)
    );

    assign rx_flag = rdy.rx;
    assign tx_flag = rdy.tx;

    // a host data read pulls the ack line, a host data write pulls the strobe line
    assign pull[HS_ACK] = req.data_rd;
    assign pull[HS_STB] = req.data_wr;

    for (genvar gi = 0; gi < HS_LINES; gi++) begin : g_hs
        mbx_hs_line #(
            .OFF_W  (HS_OFF_W),
            .LO_OFF (hs_lo_off(gi)),
            .HI_OFF (hs_hi_off(gi))
        ) u_line (
            .clk       (clk),
            .rst       (rst),
            .host_pull (pull[gi]),
            .cop_wr    (c_hs_wr),
            .cop_off   (c_hs_off),
            .line_q    (line_q[gi])
        );
    end

    assign ack_n = line_q[HS_ACK];
    assign stb_n = line_q[HS_STB];

    mbx_irq_gate #(.IEN_W(IEN_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .ien_wr    (c_ien_wr),
        .ien_wdata (c_ien_wdata),
        .src_n     (irq_src_n),
        .ien_q     (ien_q),
        .irq       (cop_irq)
    );

    assign cop_vec = DATA_W'(IRQ_VEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cop_rst <= 1'b1;
        end else if (req.ctrl_wr) begin
            cop_rst <= h_wdata[0];
        end
    end

    always_comb begin
        h_rdata = '0;
        if (req.data_rd) begin
            h_rdata = data_q;
        end else if (req.stat_rd) begin
            h_rdata = status_byte(rdy);
        end
    end

    assign c_rdata = data_q;
endmodule

// File: rtl/cpu_mailbox_chk.sv
module cpu_mailbox_chk #(
    parameter int DEC_W = 8,
    parameter int BASE  = 'hB8,
    parameter int IEN_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [DEC_W-1:0] h_port,
    input logic             h_wr,
    input logic             h_rd,
    input logic [7:0]       h_wdata,
    input logic [7:0]       h_rdata,
    input logic             c_data_wr,
    input logic             c_data_rd,
    input logic [7:0]       c_wdata,
    input logic [7:0]       c_rdata,
    input logic             c_ien_wr,
    input logic [IEN_W-1:0] c_ien_wdata,
    input logic [IEN_W-1:0] ien_q,
    input logic             cop_irq,
    input logic             cop_rst,
    input logic             rx_flag,
    input logic             tx_flag
);
    localparam logic [DEC_W-1:0] CTRL_A = DEC_W'(BASE);
    localparam logic [DEC_W-1:0] DATA_A = DEC_W'(BASE + 1);

    logic host_dw;
    logic host_dr;
    logic host_cw;
    logic host_sr;

    assign host_dw = h_wr && (h_port == DATA_A);
    assign host_dr = h_rd && (h_port == DATA_A);
    assign host_cw = h_wr && (h_port == CTRL_A);
    assign host_sr = h_rd && (h_port == CTRL_A);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cop_rst && !rx_flag && !tx_flag && ien_q == '0));

    a_r2_cop_wins: assert property (@(posedge clk) disable iff (rst)
        (host_dw && c_data_wr) |=> c_rdata == $past(c_wdata));

    a_r2_host_data: assert property (@(posedge clk) disable iff (rst)
        (host_dw && !c_data_wr) |=> c_rdata == $past(h_wdata));

    a_r3_tx_set: assert property (@(posedge clk) disable iff (rst)
        (host_dw && !c_data_rd) |=> tx_flag);

    a_r4_rx_set: assert property (@(posedge clk) disable iff (rst)
        (host_dr && !c_data_wr) |=> rx_flag);

    a_r5_rx_clear: assert property (@(posedge clk) disable iff (rst)
        c_data_wr |=> !rx_flag);

    a_r5_tx_clear: assert property (@(posedge clk) disable iff (rst)
        c_data_rd |=> !tx_flag);

    a_r6_status: assert property (@(posedge clk) disable iff (rst)
        host_sr |-> h_rdata == {6'b111100, tx_flag, rx_flag});

    a_r7_cop_reset: assert property (@(posedge clk) disable iff (rst)
        host_cw |=> cop_rst == $past(h_wdata[0]));

    a_r9_ien_load: assert property (@(posedge clk) disable iff (rst)
        c_ien_wr |=> ien_q == $past(c_ien_wdata));

    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        !ien_q[0] |-> !cop_irq);
endmodule

bind cpu_mailbox cpu_mailbox_chk #(.DEC_W(DEC_W), .BASE(BASE), .IEN_W(IEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .h_port      (h_port),
    .h_wr        (h_wr),
    .h_rd        (h_rd),
    .h_wdata     (h_wdata),
    .h_rdata     (h_rdata),
    .c_data_wr   (c_data_wr),
    .c_data_rd   (c_data_rd),
    .c_wdata     (c_wdata),
    .c_rdata     (c_rdata),
    .c_ien_wr    (c_ien_wr),
    .c_ien_wdata (c_ien_wdata),
    .ien_q       (ien_q),
    .cop_irq     (cop_irq),
    .cop_rst     (cop_rst),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag)
);

// File: tb/sim_cpu_mailbox.sv
module sim_cpu_mailbox;
    localparam logic [7:0] P_CTRL = 8'hB8;
    localparam logic [7:0] P_DATA = 8'hB9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] h_port = '0;
    logic       h_wr = 1'b0;
    logic       h_rd = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       c_data_wr = 1'b0;
    logic       c_data_rd = 1'b0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic       c_hs_wr = 1'b0;
    logic [2:0] c_hs_off = '0;
    logic       c_ien_wr = 1'b0;
    logic [5:0] c_ien_wdata = '0;
    logic       irq_src_n = 1'b1;
    logic       ack_n;
    logic       stb_n;
    logic [5:0] ien_q;
    logic       cop_irq;
    logic [7:0] cop_vec;
    logic       cop_rst;

    logic [7:0] m_data;
    logic       m_rx, m_tx, m_ack, m_stb, m_rst;
    logic [5:0] m_ien;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    cpu_mailbox u0 (
        .clk(clk), .rst(rst), .h_port(h_port), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .c_data_wr(c_data_wr),
        .c_data_rd(c_data_rd), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .c_hs_wr(c_hs_wr), .c_hs_off(c_hs_off), .c_ien_wr(c_ien_wr),
        .c_ien_wdata(c_ien_wdata), .irq_src_n(irq_src_n), .ack_n(ack_n),
        .stb_n(stb_n), .ien_q(ien_q), .cop_irq(cop_irq), .cop_vec(cop_vec),
        .cop_rst(cop_rst)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        h_wr = 1'b0; h_rd = 1'b0; h_port = '0; h_wdata = '0;
        c_data_wr = 1'b0; c_data_rd = 1'b0; c_wdata = '0;
        c_hs_wr = 1'b0; c_hs_off = '0; c_ien_wr = 1'b0; c_ien_wdata = '0;
    endtask

    task automatic check_state();
        chk("R2 shared byte", c_rdata, m_data);
        chk("R3 R8 strobe line", {7'b0, stb_n}, {7'b0, m_stb});
        chk("R4 R8 ack line", {7'b0, ack_n}, {7'b0, m_ack});
        chk("R7 coprocessor reset", {7'b0, cop_rst}, {7'b0, m_rst});
        chk("R9 enable register", {2'b0, ien_q}, {2'b0, m_ien});
        chk("R9 irq gate", {7'b0, cop_irq}, {7'b0, m_ien[0] & ~irq_src_n});
        chk("R9 vector", cop_vec, 8'h03);
    endtask

    // inputs are set after a falling edge; one clock is applied
    task automatic tick();
        logic hd, hs;
        logic [7:0] er;
        #1;
        hd = (h_port == P_DATA);
        hs = (h_port == P_CTRL);
        er = 8'h00;
        if (h_rd && hd) er = m_data;
        else if (h_rd && hs) er = {6'b111100, m_tx, m_rx};
        if (h_rd) begin
            if (hd) chk("R4 host data read", h_rdata, er);
            else if (hs) chk("R6 status read", h_rdata, er);
            else chk("R10 unmapped read", h_rdata, er);
        end
        @(posedge clk);
        if (c_data_wr) m_data = c_wdata;
        else if (h_wr && hd) m_data = h_wdata;
        if (c_data_wr) m_rx = 1'b0;
        else if (h_rd && hd) m_rx = 1'b1;
        if (c_data_rd) m_tx = 1'b0;
        else if (h_wr && hd) m_tx = 1'b1;
        if (c_hs_wr && c_hs_off == 3'd5) m_stb = 1'b1;
        else if (c_hs_wr && c_hs_off == 3'd4) m_stb = 1'b0;
        else if (h_wr && hd) m_stb = 1'b0;
        if (c_hs_wr && c_hs_off == 3'd1) m_ack = 1'b1;
        else if (c_hs_wr && c_hs_off == 3'd0) m_ack = 1'b0;
        else if (h_rd && hd) m_ack = 1'b0;
        if (h_wr && hs) m_rst = h_wdata[0];
        if (c_ien_wr) m_ien = c_ien_wdata;
        @(negedge clk);
        check_state();
        clear_inputs();
    endtask

    task automatic host_write(input logic [7:0] p, input logic [7:0] d);
        h_wr = 1'b1; h_port = p; h_wdata = d; tick();
    endtask

    task automatic host_read(input logic [7:0] p);
        h_rd = 1'b1; h_port = p; tick();
    endtask

    task automatic hs_write(input logic [2:0] off);
        c_hs_wr = 1'b1; c_hs_off = off; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        m_data = '0; m_rx = 1'b0; m_tx = 1'b0; m_ack = 1'b1; m_stb = 1'b1;
        m_rst = 1'b1; m_ien = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values at the ports
        chk("R1 data after reset", c_rdata, 8'h00);
        chk("R1 strobe after reset", {7'b0, stb_n}, 8'h01);
        chk("R1 ack after reset", {7'b0, ack_n}, 8'h01);
        chk("R1 cop reset held", {7'b0, cop_rst}, 8'h01);
        chk("R1 enables after reset", {2'b0, ien_q}, 8'h00);
        chk("R1 irq after reset", {7'b0, cop_irq}, 8'h00);
        host_read(P_CTRL); // R1 R6: status 0xF0

        // full byte sweep of both transfer directions (R2 R3 R4 R5 R6)
        for (int d = 0; d < 256; d++) begin
            host_write(P_DATA, 8'(d));
            host_read(P_CTRL);
            c_data_rd = 1'b1; tick();
            host_read(P_CTRL);
            c_data_wr = 1'b1; c_wdata = ~8'(d); tick();
            host_read(P_DATA);
            host_read(P_CTRL);
            hs_write(3'd1);
            hs_write(3'd5);
        end

        // R8: every handshake offset from both line states
        for (int off = 0; off < 8; off++) begin
            host_write(P_DATA, 8'(off));
            host_read(P_DATA);
            hs_write(3'(off));
            hs_write(3'd1);
            hs_write(3'd5);
            hs_write(3'(off));
        end

        // R9: every enable value against both source levels
        for (int v = 0; v < 64; v++) begin
            for (int s = 0; s < 2; s++) begin
                irq_src_n = s[0];
                c_ien_wr = 1'b1; c_ien_wdata = 6'(v); tick();
                irq_src_n = ~s[0];
                tick();
            end
        end

        // R7: control bit 0 drives the coprocessor reset
        host_write(P_CTRL, 8'h00);
        host_write(P_CTRL, 8'hFE);
        host_write(P_CTRL, 8'h01);
        host_write(P_CTRL, 8'hFF);
        host_write(P_CTRL, 8'h02);
        host_read(P_CTRL);

        // R10: unmapped ports have no effect
        host_write(P_DATA, 8'hA5);
        hs_write(3'd5);
        for (int p = 0; p < 256; p += 17) begin
            if (8'(p) != P_DATA && 8'(p) != P_CTRL) begin
                host_write(8'(p), 8'h5A);
                host_read(8'(p));
                host_read(P_CTRL);
            end
        end
        host_write(8'hB7, 8'h01);
        host_write(8'hBA, 8'h01);
        host_read(P_CTRL);

        // R2 R5 R8: simultaneous host and coprocessor accesses
        h_wr = 1'b1; h_port = P_DATA; h_wdata = 8'h11;
        c_data_wr = 1'b1; c_wdata = 8'h22; tick();
        host_read(P_CTRL);
        h_rd = 1'b1; h_port = P_DATA; c_data_wr = 1'b1; c_wdata = 8'h33; tick();
        host_read(P_CTRL);
        h_wr = 1'b1; h_port = P_DATA; h_wdata = 8'h44; c_data_rd = 1'b1; tick();
        host_read(P_CTRL);
        h_wr = 1'b1; h_port = P_DATA; h_wdata = 8'h55; c_hs_wr = 1'b1; c_hs_off = 3'd5; tick();
        h_rd = 1'b1; h_port = P_DATA; c_hs_wr = 1'b1; c_hs_off = 3'd1; tick();
        h_wr = 1'b1; h_port = P_DATA; h_wdata = 8'h66; c_hs_wr = 1'b1; c_hs_off = 3'd4; tick();
        host_read(P_CTRL);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule